// File: doc/BRIEF.md
# Ping-Pong Page Writer for a NAND Data Bus

This block moves one page of data, 512 bytes by default, from a DMA source onto the byte-wide data bus of a NAND flash device. It stages the data through two 16-byte buffers that take turns. While one buffer is being written out to the flash, the DMA source refills the other one. Every byte that goes out on the bus is also presented on a sideband port that feeds either a Hamming or a Reed-Solomon ECC calculator. A configuration bit selects which one.

Software arms the engine by setting an auto-load select bit and then a go bit. On the rising edge of their AND, the engine raises a DMA request and collects 32 bytes, which fills both buffers. It then emits write strobes, taking buffer 0 first. Each time a buffer drains, the engine requests a refill for that buffer. If the next buffer is not full yet, the strobes pause. After the strobe for the last byte rises, the engine pulses `done` and goes idle. Clearing the go bit at any earlier point aborts the page.

Top module: `nand_pp_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `nand_we_n` is 1, and `dma_req`, `busy`, `done`, `ecc_ham_vld` and `ecc_rs_vld` are all 0.
- R2: A transfer starts only on a rising edge of `cfg_autoload_sel & cfg_go` while the block is idle. In the cycle after that edge, `busy` and `dma_req` are both 1. Holding the bits high after a page has finished does not start a second page.
- R3: No write strobe is issued before both buffers are full. Exactly 32 DMA bytes are accepted before the first falling edge of `nand_we_n`.
- R4: The bytes written to the bus are the accepted DMA bytes in acceptance order. The first byte comes from buffer 0, and no byte is lost or repeated.
- R5: Each write cycle holds `nand_we_n` low for `cfg_we_low`+1 clocks and then high for at least `cfg_we_high`+1 clocks. `nand_dq` does not change while the strobe is low.
- R6: When the next buffer is already full as the current one drains, the next strobe falls right after the high phase. The high time is then exactly `cfg_we_high`+1 clocks, and there is no gap at the buffer switch.
- R7: A DMA byte is accepted in every cycle where both `dma_req` and `dma_ack` are 1. Once raised, `dma_req` falls only after its target buffer has received 16 bytes. A page takes exactly 512 accepted bytes.
- R8: If the next buffer is not full when the current one empties, `nand_we_n` stays high until data arrives. Writing then continues with no loss or repeat.
- R9: With each byte launched, the block gives a one-cycle pulse on `ecc_ham_vld` when `cfg_ecc_rs` is 0, or on `ecc_rs_vld` when it is 1, never on both. The pulse falls in the first low cycle of that byte's strobe, with the byte on `ecc_data`.
- R10: Exactly 512 strobes are issued. `done` is 1 for one cycle, in the cycle after the one in which `nand_we_n` rose for byte 512. After that, `busy` and `dma_req` are 0.
- R11: Clearing `cfg_go` while `busy` aborts the page. In the next cycle `busy` is 0, `dma_req` is 0 and `nand_we_n` is 1, and no more strobes follow. Both buffers and the byte count are cleared, so a restart sends a full page from byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_autoload_sel | input | 1 | Auto-load select; must be 1 to arm |
| cfg_go | input | 1 | Go bit; rising edge with select starts, clearing aborts |
| cfg_ecc_rs | input | 1 | ECC route: 0 Hamming, 1 Reed-Solomon |
| cfg_we_low | input | 4 | Strobe low time minus one, in clocks |
| cfg_we_high | input | 4 | Strobe high time minus one, in clocks |
| dma_req | output | 1 | Refill request toward the DMA source |
| dma_ack | input | 1 | DMA byte valid this cycle |
| dma_data | input | 8 | DMA byte |
| nand_we_n | output | 1 | Active-low NAND write strobe |
| nand_dq | output | 8 | NAND data bus |
| ecc_data | output | 8 | Byte presented to the ECC calculators |
| ecc_ham_vld | output | 1 | Byte valid for the Hamming calculator |
| ecc_rs_vld | output | 1 | Byte valid for the Reed-Solomon calculator |
| busy | output | 1 | Page transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the DMA source drives `dma_ack` only while it sees `dma_req` high. They also assume that the timing fields and the ECC route do not change while a page is in flight. The stimulus respects both assumptions. It decides the acknowledge from the request it samples on the falling clock edge. It changes configuration only before a start or after a page has finished or been aborted. The DMA pacing is varied from one byte per clock down to one byte every ten clocks, so that both the gap-free buffer switch and the stall path are exercised.

// File: rtl/nand_pp_pkg.sv
package nand_pp_pkg;
  typedef enum logic [1:0] {
    STB_IDLE = 2'd0,
    STB_LOW  = 2'd1,
    STB_HIGH = 2'd2
  } stb_state_e;
endpackage

// File: rtl/nand_pp_buffer.sv
// One staging buffer: filled once up to DEPTH bytes, then drained in order.
module nand_pp_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              full,
  output logic              last_wr,
  output logic              last_rd,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] FULL_V = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_V = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;

  assign full    = (wr_ptr_q == FULL_V);
  assign last_wr = wr_en & (wr_ptr_q == LAST_V);
  assign last_rd = rd_en & (rd_ptr_q == LAST_V);
  assign rd_data = mem[rd_ptr_q[IDX_W-1:0]];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else if (wr_en) begin
      wr_ptr_d = wr_ptr_q + 1'b1;
    end else if (rd_en) begin
      if (rd_ptr_q == LAST_V) begin
        wr_ptr_d = '0;
        rd_ptr_d = '0;
      end else begin
        rd_ptr_d = rd_ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wr_ptr_q[IDX_W-1:0]] <= wr_data;
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> full);
endmodule

// File: rtl/nand_pp_strobe.sv
// Write strobe sequencer: low for lo+1 clocks, high for hi+1 clocks.
module nand_pp_strobe
  import nand_pp_pkg::*;
#(
  parameter int TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              launch,
  input  logic [TIME_W-1:0] lo_cyc,
  input  logic [TIME_W-1:0] hi_cyc,
  output logic              we_n,
  output logic              ready,
  output logic              rising
);
  stb_state_e        state_q, state_d;
  logic [TIME_W-1:0] cnt_q, cnt_d;

  assign we_n   = (state_q != STB_LOW);
  assign ready  = (state_q == STB_IDLE) | ((state_q == STB_HIGH) & (cnt_q == '0));
  assign rising = (state_q == STB_LOW) & (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clr) begin
      state_d = STB_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        STB_IDLE: if (launch) begin
          state_d = STB_LOW;
          cnt_d   = lo_cyc;
        end
        STB_LOW: if (cnt_q == '0) begin
          state_d = STB_HIGH;
          cnt_d   = hi_cyc;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
        STB_HIGH: if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (launch) begin
          state_d = STB_LOW;
          cnt_d   = lo_cyc;
        end else begin
          state_d = STB_IDLE;
        end
        default: state_d = STB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STB_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  a_r5_launch_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> ready);
  a_r5_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == STB_LOW && cnt_q != '0 && !clr) |=> !we_n);
endmodule

// File: rtl/nand_pp_writer.sv
module nand_pp_writer #(
  parameter int DATA_W     = 8,
  parameter int BUF_DEPTH  = 16,
  parameter int PAGE_BYTES = 512,
  parameter int TIME_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_autoload_sel,
  input  logic              cfg_go,
  input  logic              cfg_ecc_rs,
  input  logic [TIME_W-1:0] cfg_we_low,
  input  logic [TIME_W-1:0] cfg_we_high,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic [DATA_W-1:0] dma_data,
  output logic              nand_we_n,
  output logic [DATA_W-1:0] nand_dq,
  output logic [DATA_W-1:0] ecc_data,
  output logic              ecc_ham_vld,
  output logic              ecc_rs_vld,
  output logic              busy,
  output logic              done
);
  localparam int FILLS  = PAGE_BYTES / BUF_DEPTH;
  localparam int FILL_W = $clog2(FILLS + 1);
  localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
  localparam logic [FILL_W-1:0] FILLS_V = FILL_W'(FILLS);
  localparam logic [CNT_W-1:0]  PAGE_V  = CNT_W'(PAGE_BYTES);

  // control state
  logic              busy_q, busy_d, arm_q, gate_q, gate_d;
  logic              fill_sel_q, fill_sel_d, drain_sel_q, drain_sel_d;
  logic [FILL_W-1:0] fills_q, fills_d;
  logic [CNT_W-1:0]  sent_q, sent_d;
  logic [DATA_W-1:0] dq_q, dq_d;
  logic              ham_q, rs_q, rise_q, rise_d, done_q;

  // buffer and strobe wiring
  logic [1:0]        buf_full, buf_wr, buf_rd, buf_last_wr, buf_last_rd;
  logic [DATA_W-1:0] buf_rdata [2];
  logic              stb_ready, stb_rising, stb_we_n;

  logic trig, start, abort, accept, launch, fin;

  assign trig    = cfg_autoload_sel & cfg_go;
  assign start   = ~busy_q & trig & ~arm_q;
  assign abort   = busy_q & ~cfg_go;
  assign dma_req = busy_q & (fills_q != FILLS_V) & ~buf_full[fill_sel_q];
  assign accept  = dma_req & dma_ack;
  assign launch  = busy_q & ~abort & gate_q & stb_ready
                 & buf_full[drain_sel_q] & (sent_q != PAGE_V);
  assign fin     = busy_q & ~abort & stb_ready & (sent_q == PAGE_V);

  for (genvar g = 0; g < 2; g++) begin : g_buf
    assign buf_wr[g] = accept & (fill_sel_q == 1'(g));
    assign buf_rd[g] = launch & (drain_sel_q == 1'(g));
    nand_pp_buffer #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (abort),
      .wr_en   (buf_wr[g]),
      .wr_data (dma_data),
      .rd_en   (buf_rd[g]),
      .full    (buf_full[g]),
      .last_wr (buf_last_wr[g]),
      .last_rd (buf_last_rd[g]),
      .rd_data (buf_rdata[g])
    );
  end

  nand_pp_strobe #(.TIME_W(TIME_W)) u_stb (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (abort),
    .launch (launch),
    .lo_cyc (cfg_we_low),
    .hi_cyc (cfg_we_high),
    .we_n   (stb_we_n),
    .ready  (stb_ready),
    .rising (stb_rising)
  );

  always_comb begin
    busy_d      = busy_q;
    gate_d      = gate_q;
    fill_sel_d  = fill_sel_q;
    fills_d     = fills_q;
    drain_sel_d = drain_sel_q;
    sent_d      = sent_q;
    dq_d        = dq_q;
    if (start) busy_d = 1'b1;
    else if (abort || fin) busy_d = 1'b0;
    if (start || abort || fin) begin
      gate_d      = 1'b0;
      fill_sel_d  = 1'b0;
      fills_d     = '0;
      drain_sel_d = 1'b0;
      sent_d      = '0;
    end else begin
      if (busy_q && (&buf_full)) gate_d = 1'b1;
      if (|buf_last_wr) begin
        fill_sel_d = ~fill_sel_q;
        fills_d    = fills_q + 1'b1;
      end
      if (|buf_last_rd) drain_sel_d = ~drain_sel_q;
      if (launch) begin
        sent_d = sent_q + 1'b1;
        dq_d   = buf_rdata[drain_sel_q];
      end
    end
    rise_d = stb_rising & (sent_q == PAGE_V) & ~abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      arm_q       <= 1'b0;
      gate_q      <= 1'b0;
      fill_sel_q  <= 1'b0;
      fills_q     <= '0;
      drain_sel_q <= 1'b0;
      sent_q      <= '0;
      dq_q        <= '0;
      ham_q       <= 1'b0;
      rs_q        <= 1'b0;
      rise_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      busy_q      <= busy_d;
      arm_q       <= trig;
      gate_q      <= gate_d;
      fill_sel_q  <= fill_sel_d;
      fills_q     <= fills_d;
      drain_sel_q <= drain_sel_d;
      sent_q      <= sent_d;
      dq_q        <= dq_d;
      ham_q       <= launch & ~cfg_ecc_rs;
      rs_q        <= launch & cfg_ecc_rs;
      rise_q      <= rise_d;
      done_q      <= rise_q;
    end
  end

  assign nand_we_n   = stb_we_n;
  assign nand_dq     = dq_q;
  assign ecc_data    = dq_q;
  assign ecc_ham_vld = ham_q;
  assign ecc_rs_vld  = rs_q;
  assign busy        = busy_q;
  assign done        = done_q;

  a_r2_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> busy);
  a_r5_dq_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_dq));
  a_r9_ecc_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_ham_vld || ecc_rs_vld) |-> !nand_we_n);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(nand_we_n) && !$past(nand_we_n, 2)));
  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_go) |=> (!busy && nand_we_n && !dma_req));
endmodule

// File: tb/sim_nand_pp_writer.sv
`timescale 1ns/1ps
module sim_nand_pp_writer;
  localparam int PAGE = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_autoload_sel = 1'b0, cfg_go = 1'b0, cfg_ecc_rs = 1'b0;
  logic [3:0] cfg_we_low = '0, cfg_we_high = '0;
  logic dma_req, dma_ack = 1'b0;
  logic [7:0] dma_data = '0;
  logic nand_we_n, ecc_ham_vld, ecc_rs_vld, busy, done;
  logic [7:0] nand_dq, ecc_data;

  always #2.5 clk = ~clk;

  nand_pp_writer u0 (.*);

  // rows: [15:12] low, [11:8] high, [7:4] ecc route, [3:0] dma gap
  localparam logic [15:0] VEC [4] = '{16'h0000, 16'h2110, 16'h1309, 16'h0019};

  int checks = 0, fails = 0;
  int seed, gap_cfg, lo_cfg, hi_cfg;
  int dma_idx, gap_cnt, ack_total, lo_len, hi_len, wr_idx, ecc_idx, ham_cnt, rs_cnt;
  int done_cnt, done_bad, rise_age, first_fall_acks, err_byte, err_lo, hi_short, hi_long;
  int err_stable, err_ecc, err_reqdrop;
  bit ack_drv, prev_req, prev_we = 1'b1, fall_seen, aborting;
  logic [7:0] fall_data;

  function automatic logic [7:0] pat(input int sd, input int k);
    return 8'(k * 37 + sd * 11 + 5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_mon();
    dma_idx = 0; gap_cnt = 0; ack_total = 0; lo_len = 0; hi_len = 0; wr_idx = 0;
    ecc_idx = 0; ham_cnt = 0; rs_cnt = 0; done_cnt = 0; done_bad = 0; rise_age = 0;
    first_fall_acks = -1; err_byte = 0; err_lo = 0; hi_short = 0; hi_long = 0;
    err_stable = 0; err_ecc = 0; err_reqdrop = 0; ack_drv = 1'b0; dma_ack = 1'b0;
    fall_seen = 1'b0;
  endtask

  // DMA source model and bus monitor, sampled away from the active edge
  always @(negedge clk) if (rst_n) begin
    if (ack_drv) begin
      ack_total++; dma_idx++; gap_cnt = gap_cfg;
    end else if (gap_cnt > 0) gap_cnt--;
    ack_drv  = dma_req && (gap_cnt == 0);
    dma_ack  = ack_drv;
    dma_data = pat(seed, dma_idx);
    if (prev_req && !dma_req && !aborting && (ack_total % 16 != 0)) err_reqdrop++;
    if (!nand_we_n && prev_we) begin
      if (!fall_seen) begin first_fall_acks = ack_total; fall_seen = 1'b1; end
      else if (hi_len > hi_cfg + 1) hi_long++;
      else if (hi_len < hi_cfg + 1) hi_short++;
      lo_len = 1; fall_data = nand_dq;
    end else if (!nand_we_n) lo_len++;
    if (nand_we_n && !prev_we) begin
      if (lo_len != lo_cfg + 1) err_lo++;
      if (nand_dq != fall_data) err_stable++;
      if (nand_dq != pat(seed, wr_idx)) err_byte++;
      wr_idx++; hi_len = 1; rise_age = 0;
    end else if (nand_we_n) begin hi_len++; rise_age++; end
    if (ecc_ham_vld || ecc_rs_vld) begin
      if (ecc_data != pat(seed, ecc_idx) || (ecc_ham_vld && ecc_rs_vld)) err_ecc++;
      ecc_idx++;
      if (ecc_ham_vld) ham_cnt++;
      if (ecc_rs_vld) rs_cnt++;
    end
    if (done) begin
      done_cnt++;
      if (!(rise_age == 1 && wr_idx == PAGE)) done_bad++;
    end
    prev_req = dma_req;
    prev_we  = nand_we_n;
  end

  task automatic run_page(input logic [15:0] v, input int sd);
    int waited;
    @(negedge clk); #1;
    cfg_we_low = v[15:12]; cfg_we_high = v[11:8]; cfg_ecc_rs = v[4];
    lo_cfg = int'(v[15:12]); hi_cfg = int'(v[11:8]); gap_cfg = int'(v[3:0]);
    seed = sd; reset_mon();
    cfg_autoload_sel = 1'b1; cfg_go = 1'b1;
    @(negedge clk); #1;
    check(busy && dma_req, "R2 start raises busy and dma_req", int'({busy, dma_req}), 3);
    waited = 0;
    while (done_cnt == 0 && waited < 30000) begin @(negedge clk); waited++; end
    repeat (20) @(negedge clk);
    #1;
    check(wr_idx == PAGE, "R10 strobe count", wr_idx, PAGE);
    check(done_cnt == 1 && done_bad == 0, "R10 done pulse timing", done_cnt * 10 + done_bad, 10);
    check(!busy && !dma_req, "R2 held go does not restart", int'({busy, dma_req}), 0);
    check(err_byte == 0, "R4 byte order", err_byte, 0);
    check(first_fall_acks == 32, "R3 acks before first strobe", first_fall_acks, 32);
    check(err_lo == 0 && hi_short == 0, "R5 strobe low/high widths", err_lo + hi_short, 0);
    check(err_stable == 0, "R5 data stable while low", err_stable, 0);
    if (gap_cfg == 0) check(hi_long == 0, "R6 gap-free buffer switch", hi_long, 0);
    else begin
      check(hi_long > 0, "R8 stall observed", hi_long, 1);
      check(err_byte == 0 && wr_idx == PAGE, "R8 no loss after stall", err_byte, 0);
    end
    check(err_reqdrop == 0 && ack_total == PAGE, "R7 request per 16 bytes", ack_total, PAGE);
    check(err_ecc == 0 && ecc_idx == PAGE, "R9 ecc data", err_ecc, 0);
    if (v[4]) check(rs_cnt == PAGE && ham_cnt == 0, "R9 route to Reed-Solomon", rs_cnt, PAGE);
    else      check(ham_cnt == PAGE && rs_cnt == 0, "R9 route to Hamming", ham_cnt, PAGE);
    cfg_go = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int w, held_idx;
    reset_mon(); seed = 0; gap_cfg = 0; lo_cfg = 0; hi_cfg = 0;
    repeat (3) @(negedge clk);
    #1;
    check(nand_we_n && !dma_req && !busy && !done, "R1 in reset", int'({nand_we_n, dma_req, busy, done}), 8);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(nand_we_n && !dma_req && !busy && !done && !ecc_ham_vld && !ecc_rs_vld,
          "R1 after reset", int'({nand_we_n, dma_req, busy, done}), 8);

    for (int i = 0; i < 4; i++) run_page(VEC[i], i + 1);

    // abort in the middle of a slow page
    @(negedge clk); #1;
    cfg_we_low = 4'd1; cfg_we_high = 4'd1; cfg_ecc_rs = 1'b0;
    lo_cfg = 1; hi_cfg = 1; gap_cfg = 3; seed = 7; reset_mon();
    cfg_autoload_sel = 1'b1; cfg_go = 1'b1;
    w = 0;
    while (wr_idx < 40 && w < 20000) begin @(negedge clk); w++; end
    #1; aborting = 1'b1; cfg_go = 1'b0;
    @(negedge clk); #1;
    check(!busy && !dma_req && nand_we_n, "R11 abort clears outputs",
          int'({busy, dma_req, nand_we_n}), 1);
    held_idx = wr_idx;
    repeat (12) @(negedge clk);
    #1;
    check(wr_idx == held_idx && nand_we_n && !busy, "R11 no strobes after abort", wr_idx, held_idx);
    aborting = 1'b0;
    run_page(16'h0110, 9);
    check(wr_idx == PAGE && err_byte == 0 && first_fall_acks == 32,
          "R11 restart sends whole page from byte 0", wr_idx, PAGE);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule